// File: doc/BRIEF.md
# Pipeline Interlock and Redirect Controller

This block keeps a five-stage in-order pipeline correct without any operand forwarding. Each cycle it compares the source registers of the instruction waiting in decode with the destination registers of older instructions that have not yet written their results back. If a needed value is still in flight, it raises a stall. A stall freezes the program counter and the fetch/decode register, and places an empty slot into the decode/execute register. When a taken branch or a jump resolves in the execute stage, the block raises a one-cycle flush that discards the two wrong-path instructions behind it.

The controller keeps its own short shift record of each downstream instruction's destination and write-enable. This record advances in step with the pipeline registers. Bubbles and flushed slots enter the record as non-writing entries. The parameter `WB_OVERLAP` states how the register file behaves. When it is set, the file writes in the first half-cycle and reads in the second, so a producer that has reached write-back no longer causes a stall. When it is clear, the write-back stage is compared as well.

Top module: `hazard_ctl`

## Requirements
- R1: While reset is held low, and on the first cycle after it with no redirect, `pc_we`=1, `ifid_we`=1, `idex_bubble`=0 and `flush`=0, whatever the decode fields are.
- R2: A stall is signalled as `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1. It is raised when a decode source that is marked as used equals the destination of a register-writing instruction in the execute stage.
- R3: With `WB_OVERLAP`=1, a dependence on the instruction just ahead (in execute) holds decode for exactly 2 cycles. A dependence on the instruction two ahead (in memory) holds it for exactly 1 cycle. A producer in write-back causes no stall, so no stall ever lasts 3 cycles.
- R4: A source or destination equal to register 0 never causes a stall.
- R5: An older instruction with `id_reg_write`=0 when it was issued (for example a store or a branch) never causes a stall, even if its destination field matches.
- R6: `id_rs` takes part in the comparison only when `id_use_rs`=1, and `id_rt` only when `id_use_rt`=1.
- R7: `ex_redirect`=1 gives `flush`=1 in the same cycle, with `pc_we`=1, `ifid_we`=1 and `idex_bubble`=0, even when a dependence exists. Flush has priority over stall.
- R8: The instruction in decode during a flush never becomes a producer. A later reader of its destination is not stalled by it.
- R9: A decode destination that equals an in-flight destination (write-after-write), or an in-flight source (write-after-read), causes no stall unless a used source also matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs | input | REG_BITS | First source register of the decode instruction |
| id_rt | input | REG_BITS | Second source register of the decode instruction |
| id_use_rs | input | 1 | Decode instruction reads `id_rs` |
| id_use_rt | input | 1 | Decode instruction reads `id_rt` |
| id_dest | input | REG_BITS | Destination register of the decode instruction |
| id_reg_write | input | 1 | Decode instruction writes the register file |
| ex_redirect | input | 1 | Taken branch or jump resolved in execute |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields entering decode/execute |
| flush | output | 1 | Discard the fetch/decode and decode/execute contents |

## Verification
The bench places a reader at distances of one, two and three slots behind a producer. These three cases separate a two-cycle stall, a one-cycle stall and no stall, which shows that the write-back stage is correctly left out of the comparison. Register 0 targets, non-writing producers and sources marked as unused all repeat a matching register number. This confirms that a number match alone never stalls. Redirects are applied both while a dependence exists and while the decode slot holds a writer. This shows that flush overrides the stall and that a squashed writer leaves no trace. A write-after-write case checks that a matching destination alone does not stall.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int REG_BITS   = 5,
  parameter bit WB_OVERLAP = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REG_BITS-1:0] id_rs,
  input  logic [REG_BITS-1:0] id_rt,
  input  logic                id_use_rs,
  input  logic                id_use_rt,
  input  logic [REG_BITS-1:0] id_dest,
  input  logic                id_reg_write,
  input  logic                ex_redirect,
  output logic                pc_we,
  output logic                ifid_we,
  output logic                idex_bubble,
  output logic                flush
);
  localparam int DEPTH = WB_OVERLAP ? 2 : 3;

  logic [REG_BITS-1:0] dst_q [DEPTH];
  logic [DEPTH-1:0]    wr_q;
  logic [DEPTH-1:0]    hit;
  logic                stall;

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign hit[s] = wr_q[s] && (dst_q[s] != '0) &&
                    ((id_use_rs && (id_rs == dst_q[s])) ||
                     (id_use_rt && (id_rt == dst_q[s])));
  end

  assign stall       = (|hit) & ~ex_redirect;
  assign flush       = ex_redirect;
  assign pc_we       = ~stall;
  assign ifid_we     = ~stall;
  assign idex_bubble = stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) dst_q[s] <= '0;
      wr_q <= '0;
    end else begin
      dst_q[0] <= id_dest;
      wr_q[0]  <= id_reg_write & ~stall & ~ex_redirect;
      for (int s = 1; s < DEPTH; s++) begin
        dst_q[s] <= dst_q[s-1];
        wr_q[s]  <= wr_q[s-1];
      end
    end
  end
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int REG_BITS   = 5,
  parameter bit WB_OVERLAP = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [REG_BITS-1:0] id_rs,
  input logic [REG_BITS-1:0] id_rt,
  input logic                id_use_rs,
  input logic                id_use_rt,
  input logic                ex_redirect,
  input logic                pc_we,
  input logic                ifid_we,
  input logic                idex_bubble,
  input logic                flush
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !idex_bubble && pc_we && ifid_we);

  // R7
  redirect_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |-> flush && pc_we && ifid_we && !idex_bubble);

  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!id_use_rs || id_rs == '0) && (!id_use_rt || id_rt == '0)) |-> !idex_bubble);

  // R6
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_use_rs && !id_use_rt) |-> !idex_bubble);

  // R2
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_bubble && !ex_redirect) |-> (!pc_we && !ifid_we && !flush));

  if (WB_OVERLAP) begin : g_len
    // R3
    stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idex_bubble && $past(idex_bubble)) |=> !idex_bubble);
  end
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_BITS(REG_BITS), .WB_OVERLAP(WB_OVERLAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
  .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .ex_redirect(ex_redirect),
  .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble), .flush(flush)
);

// File: tb/sim_hazard_ctl.sv
`timescale 1ns/1ps
module sim_hazard_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] id_rs = '0, id_rt = '0, id_dest = '0;
  logic       id_use_rs = 1'b0, id_use_rt = 1'b0, id_reg_write = 1'b0, ex_redirect = 1'b0;
  logic       pc_we, ifid_we, idex_bubble, flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int md [2];
  bit mw [2];

  always #2.5 clk = ~clk;

  hazard_ctl u0 (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
    .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .id_dest(id_dest),
    .id_reg_write(id_reg_write), .ex_redirect(ex_redirect),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble), .flush(flush)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_stall(input int rs, input bit urs, input int rt, input bit urt, input bit redir);
    bit h = 1'b0;
    for (int k = 0; k < 2; k++)
      if (mw[k] && md[k] != 0 && ((urs && rs == md[k]) || (urt && rt == md[k]))) h = 1'b1;
    return h && !redir;
  endfunction

  // one decode cycle; exp_stall / exp_flush computed by hand from the requirements
  task automatic step(input int rs, input bit urs, input int rt, input bit urt,
                      input int dest, input bit we, input bit redir,
                      input bit exp_stall, input bit exp_flush, input string req);
    bit ms;
    @(negedge clk);
    id_rs = rs[4:0]; id_use_rs = urs; id_rt = rt[4:0]; id_use_rt = urt;
    id_dest = dest[4:0]; id_reg_write = we; ex_redirect = redir;
    #1;
    ms = model_stall(rs, urs, rt, urt, redir);
    check(idex_bubble == exp_stall, req, idex_bubble, exp_stall);
    check(pc_we == !exp_stall && ifid_we == !exp_stall, req, {pc_we, ifid_we}, exp_stall ? 0 : 3);
    check(flush == exp_flush, req, flush, exp_flush);
    check(idex_bubble == ms, {req, " model"}, idex_bubble, ms);
    md[1] = md[0]; mw[1] = mw[0];
    md[0] = dest;  mw[0] = we && !ms && !redir;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "drain");
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin md[k] = 0; mw[k] = 1'b0; end
    id_rs = 5'd3; id_use_rs = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    check(pc_we && ifid_we && !idex_bubble && !flush, "R1 reset", {pc_we, ifid_we, idex_bubble, flush}, 12);
    rst_n = 1'b1;
    step(3, 1, 0, 0, 0, 0, 0, 0, 0, "R1 first cycle");

    // producer then immediate reader: 2-cycle stall (R2, R3)
    step(0, 0, 0, 0, 3, 1, 0, 0, 0, "R2 producer");
    step(3, 1, 2, 1, 4, 1, 0, 1, 0, "R2 reader stalls on EX");
    step(3, 1, 2, 1, 4, 1, 0, 1, 0, "R3 second stall cycle");
    step(3, 1, 2, 1, 4, 1, 0, 0, 0, "R3 released at WB");
    step(0, 0, 4, 1, 0, 0, 0, 1, 0, "R2 rt dependence");
    step(0, 0, 4, 1, 0, 0, 0, 1, 0, "R3 rt second cycle");
    step(0, 0, 4, 1, 0, 0, 0, 0, 0, "R3 rt released");
    nop(2);

    // gap of one: 1-cycle stall (R3)
    step(0, 0, 0, 0, 9, 1, 0, 0, 0, "R3 producer");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 gap");
    step(9, 1, 0, 0, 0, 0, 0, 1, 0, "R3 Mem stall");
    step(9, 1, 0, 0, 0, 0, 0, 0, 0, "R3 Mem released");
    // gap of two: no stall
    step(0, 0, 0, 0, 6, 1, 0, 0, 0, "R3 producer");
    nop(2);
    step(6, 1, 6, 1, 0, 0, 0, 0, 0, "R3 WB no stall");

    // register 0 (R4)
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R4 writes r0");
    step(0, 1, 0, 1, 0, 0, 0, 0, 0, "R4 reads r0");
    nop(2);

    // non-writing producer (R5)
    step(0, 0, 0, 0, 7, 0, 0, 0, 0, "R5 store");
    step(7, 1, 7, 1, 0, 0, 0, 0, 0, "R5 no stall");
    nop(2);

    // unused sources (R6)
    step(0, 0, 0, 0, 8, 1, 0, 0, 0, "R6 producer");
    step(8, 0, 8, 0, 0, 0, 0, 0, 0, "R6 unused fields");
    step(1, 1, 8, 1, 0, 0, 0, 1, 0, "R6 rt used");
    step(1, 1, 8, 1, 0, 0, 0, 0, 0, "R6 released");
    nop(2);

    // flush priority (R7)
    step(0, 0, 0, 0, 10, 1, 0, 0, 0, "R7 producer");
    step(10, 1, 0, 0, 0, 0, 1, 0, 1, "R7 flush over stall");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 after flush");
    nop(2);

    // squashed writer (R8)
    step(0, 0, 0, 0, 11, 1, 1, 0, 1, "R8 wrong-path writer");
    step(11, 1, 11, 1, 0, 0, 0, 0, 0, "R8 no stall");
    nop(2);

    // WAW / WAR (R9)
    step(5, 1, 0, 0, 13, 1, 0, 0, 0, "R9 first writer");
    step(1, 1, 2, 1, 13, 1, 0, 0, 0, "R9 WAW");
    step(0, 0, 0, 0, 5, 1, 0, 0, 0, "R9 WAR");
    step(13, 1, 0, 0, 0, 0, 0, 1, 0, "R9 true RAW after WAW");
    nop(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule